// File: doc/BRIEF.md
# Multi-Mode Prescaled Pulse-Width Channel

This block is one pulse-width output channel for a motor, heater or servo driver. A programmable prescaler divides the clock by `div_val + 1` and produces the counting tick. A pulse counter measures the active phase and the inactive phase from that tick. The channel offers three waveforms. The fixed-period mode has a period of 255 or 65535 ticks and an active width taken from `hi_val`. The one-shot mode fires a single active pulse, started either by an edge on `trig_in` or by every prescaler wrap. The dual-width mode takes its active length from `hi_val` and its inactive length from `lo_val`.

The channel drives a value and an output enable for a tri-state pad. The enable is low after reset and whenever the channel is switched off. The host presents the committed settings as plain inputs. Mode, polarity, resolution and trigger source are latched when the channel starts and must be changed only while it is off. The prescaler and width values are sampled again at every cycle boundary, so an update never cuts a running cycle short. When external gating is on in the fixed-period or dual-width mode, a low level on the trigger freezes the waveform in place, and a high level lets it continue.

Top module: `pulse_chan`

## Requirements
- R1: While reset is asserted and after it is released with `chan_en` low, `pwm_oe` is 0 and `pwm_out` is 0.
- R2: With `mode_sel`=0 and `wide_res`=0, sample k (k=0 at the first enabled edge) is active exactly when floor(k/(L+1)) mod 255 < (M mod 256). L is `div_val`, M is `hi_val`, and only the low byte of M counts.
- R3: With `mode_sel`=0 and `wide_res`=1, sample k is active exactly when floor(k/(L+1)) mod 65535 < M. M=0 is never active and M=65535 is always active.
- R4: With `mode_sel`=1 and `ext_trig_en`=1, `pwm_oe` stays 0 until a rising edge on `trig_in`. The third clock edge at which `trig_in` reads high then enables the output and starts an active pulse of (L+1)*M cycles, after which the output is inactive.
- R5: In the mode of R4, a new trigger edge that arrives during a pulse restarts it. The output stays active until (L+1)*M cycles after the restart.
- R6: With `mode_sel`=1 and `ext_trig_en`=0, sample k is active exactly when (k mod (L+1)) < M. A new pulse starts on every prescaler wrap.
- R7: With `mode_sel`=2, sample k is active exactly when floor(k/(L+1)) mod (M+N) < M, where N is `lo_val`. If M+N is 0 the output stays inactive.
- R8: With `act_high`=1 the active phase drives `pwm_out` to 1. With `act_high`=0 it drives 0, and the inactive phase drives the opposite value.
- R9: One clock edge after `chan_en` is sampled low, `pwm_oe` is 0.
- R10: A change to `hi_val` or `lo_val` during a fixed-period or dual-width cycle takes effect only from the first sample of the next cycle.
- R11: With `ext_trig_en`=1 and `mode_sel` of 0 or 2, `pwm_oe` stays 0 until the third edge at which `trig_in` reads high. While running, the waveform holds its value for as many edges as `trig_in` is low, shifted by the two-stage synchroniser, and then resumes from where it stopped.
- R12: With `ext_trig_en`=0, the first clock edge that samples `chan_en` high sets `pwm_oe` to 1 and starts the cycle in its active phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel run enable |
| mode_sel | input | 2 | 0 fixed-period, 1 one-shot, 2 dual-width |
| wide_res | input | 1 | Fixed-period resolution: 0 gives a 255-tick period, 1 gives 65535 |
| ext_trig_en | input | 1 | Use `trig_in` as the start and gate source |
| act_high | input | 1 | Level driven during the active phase |
| div_val | input | PRE_W | Prescaler setting L (divide by L+1) |
| hi_val | input | CNT_W | Active width M |
| lo_val | input | CNT_W | Inactive width N (dual-width mode) |
| trig_in | input | 1 | Asynchronous trigger / gate input |
| pwm_out | output | 1 | Output value |
| pwm_oe | output | 1 | Output enable for the tri-state pad |

## Verification
The bench builds the channel with its default widths: a 16-bit prescaler, a 16-bit counter and an 8-bit narrow resolution. With prescaler settings from 0 to 5, whole 255-tick fixed periods, every small dual-width pair, the internal one-shot wrap and the retrigger case all fit in a few thousand cycles, and each sample is compared against an arithmetic formula. The 16-bit resolution is reached through widths above 255 and the two extreme widths, which separates the two periods without sweeping 65535 ticks. Freeze windows and mid-cycle width changes are placed at known sample indices so that the expected shift can be computed exactly.

// File: rtl/pulse_chan_pkg.sv
`timescale 1ns/1ps
package pulse_chan_pkg;
    typedef enum logic [1:0] {
        PM_FIXED   = 2'd0,
        PM_ONESHOT = 2'd1,
        PM_DUAL    = 2'd2,
        PM_RSVD    = 2'd3
    } pm_mode_e;
endpackage

// File: rtl/pc_trig_sync.sv
`timescale 1ns/1ps
// Synchroniser for the asynchronous trigger pin, with rising-edge detect.
module pc_trig_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic [SYNC_N:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stg = {st_q.stg[SYNC_N-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.stg[SYNC_N-1];
    assign rise  = st_q.stg[SYNC_N-1] & ~st_q.stg[SYNC_N];
endmodule

// File: rtl/pc_prescaler.sv
`timescale 1ns/1ps
// Divide-by-(limit+1) tick generator with restart and hold.
module pc_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)       st_d.cnt = '0;
        else if (hold) st_d.cnt = st_q.cnt;
        else if (tick) st_d.cnt = '0;
        else           st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = (st_q.cnt == limit);
endmodule

// File: rtl/pc_shaper.sv
`timescale 1ns/1ps
// Phase counter, shadow settings and run control for one channel.
module pc_shaper
    import pulse_chan_pkg::*;
#(
    parameter int PRE_W    = 16,
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic [1:0]       mode_sel,
    input  logic             wide_res,
    input  logic             ext_trig_en,
    input  logic             act_high,
    input  logic [PRE_W-1:0] div_val,
    input  logic [CNT_W-1:0] hi_val,
    input  logic [CNT_W-1:0] lo_val,
    input  logic             trig_lvl,
    input  logic             trig_rise,
    input  logic             pre_tick,
    output logic             pre_clr,
    output logic             pre_hold,
    output logic [PRE_W-1:0] pre_lim,
    output logic             run,
    output logic             active,
    output logic             pol
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] WIDE_LAST   = SUM_W'((64'd1 << CNT_W) - 64'd2);
    localparam logic [SUM_W-1:0] NARROW_LAST = SUM_W'((64'd1 << NARROW_W) - 64'd2);

    typedef struct packed {
        logic             run;
        logic             busy;
        logic [SUM_W-1:0] cnt;
        logic [PRE_W-1:0] lim;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
        pm_mode_e         mode;
        logic             ext;
        logic             pol;
        logic             wide;
    } shp_t;

    shp_t st_d, st_q;

    function automatic logic [CNT_W-1:0] fit_hi(input logic [CNT_W-1:0] v, input logic narrow);
        return narrow ? {{(CNT_W-NARROW_W){1'b0}}, v[NARROW_W-1:0]} : v;
    endfunction

    logic             start_ok;
    logic             frozen;
    logic [SUM_W-1:0] span;
    logic [SUM_W-1:0] hi_ext;
    logic [SUM_W-1:0] last_fixed;
    logic [CNT_W-1:0] hi_new;
    logic [CNT_W-1:0] hi_start;

    always_comb begin
        hi_ext     = {1'b0, st_q.hi};
        span       = {1'b0, st_q.hi} + {1'b0, st_q.lo};
        last_fixed = st_q.wide ? WIDE_LAST : NARROW_LAST;
        hi_new     = fit_hi(hi_val, (st_q.mode == PM_FIXED) && !st_q.wide);
        hi_start   = fit_hi(hi_val, (pm_mode_e'(mode_sel) == PM_FIXED) && !wide_res);
        frozen     = st_q.ext && (st_q.mode != PM_ONESHOT) && !trig_lvl;

        if (!ext_trig_en)                          start_ok = 1'b1;
        else if (pm_mode_e'(mode_sel) == PM_ONESHOT) start_ok = trig_rise;
        else                                       start_ok = trig_lvl;
    end

    always_comb begin
        st_d     = st_q;
        pre_clr  = 1'b0;
        pre_hold = 1'b0;
        if (!chan_en) begin
            st_d    = shp_t'('0);
            pre_clr = 1'b1;
        end else if (!st_q.run) begin
            pre_clr = 1'b1;
            if (start_ok) begin
                st_d.run  = 1'b1;
                st_d.mode = pm_mode_e'(mode_sel);
                st_d.ext  = ext_trig_en;
                st_d.pol  = act_high;
                st_d.wide = wide_res;
                st_d.lim  = div_val;
                st_d.hi   = hi_start;
                st_d.lo   = lo_val;
                st_d.cnt  = '0;
                st_d.busy = (hi_start != '0);
            end
        end else if (frozen) begin
            pre_hold = 1'b1;
        end else begin
            case (st_q.mode)
                PM_FIXED: begin
                    if (pre_tick) begin
                        if (st_q.cnt >= last_fixed) begin
                            st_d.cnt = '0;
                            st_d.lim = div_val;
                            st_d.hi  = hi_new;
                            st_d.lo  = lo_val;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PM_DUAL: begin
                    if (pre_tick && span != '0) begin
                        if (st_q.cnt >= span - 1'b1) begin
                            st_d.cnt = '0;
                            st_d.lim = div_val;
                            st_d.hi  = hi_new;
                            st_d.lo  = lo_val;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                PM_ONESHOT: begin
                    if (st_q.ext ? trig_rise : pre_tick) begin
                        st_d.cnt  = '0;
                        st_d.lim  = div_val;
                        st_d.hi   = hi_new;
                        st_d.lo   = lo_val;
                        st_d.busy = (hi_new != '0);
                        pre_clr   = st_q.ext;
                    end else if (st_q.busy && (!st_q.ext || pre_tick)) begin
                        if (st_q.cnt == hi_ext - 1'b1) begin
                            st_d.busy = 1'b0;
                            st_d.cnt  = '0;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    st_d.cnt = st_q.cnt;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= shp_t'('0);
        else        st_q <= st_d;
    end

    always_comb begin
        case (st_q.mode)
            PM_FIXED, PM_DUAL: active = (st_q.cnt < hi_ext);
            PM_ONESHOT:        active = st_q.busy;
            default:           active = 1'b0;
        endcase
    end

    assign run     = st_q.run;
    assign pol     = st_q.pol;
    assign pre_lim = st_q.lim;
endmodule

// File: rtl/pulse_chan.sv
`timescale 1ns/1ps
// One multi-mode pulse-width output channel with tri-state enable.
module pulse_chan #(
    parameter int PRE_W    = 16,
    parameter int CNT_W    = 16,
    parameter int NARROW_W = 8,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic [1:0]       mode_sel,
    input  logic             wide_res,
    input  logic             ext_trig_en,
    input  logic             act_high,
    input  logic [PRE_W-1:0] div_val,
    input  logic [CNT_W-1:0] hi_val,
    input  logic [CNT_W-1:0] lo_val,
    input  logic             trig_in,
    output logic             pwm_out,
    output logic             pwm_oe
);
    logic             trig_lvl;
    logic             trig_rise;
    logic             pre_tick;
    logic             pre_clr;
    logic             pre_hold;
    logic [PRE_W-1:0] pre_lim;
    logic             sh_run;
    logic             sh_active;
    logic             sh_pol;

    pc_trig_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (trig_in),
        .level (trig_lvl),
        .rise  (trig_rise)
    );

    pc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .hold  (pre_hold),
        .limit (pre_lim),
        .tick  (pre_tick)
    );

    pc_shaper #(.PRE_W(PRE_W), .CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_shp (
        .clk         (clk),
        .rst_n       (rst_n),
        .chan_en     (chan_en),
        .mode_sel    (mode_sel),
        .wide_res    (wide_res),
        .ext_trig_en (ext_trig_en),
        .act_high    (act_high),
        .div_val     (div_val),
        .hi_val      (hi_val),
        .lo_val      (lo_val),
        .trig_lvl    (trig_lvl),
        .trig_rise   (trig_rise),
        .pre_tick    (pre_tick),
        .pre_clr     (pre_clr),
        .pre_hold    (pre_hold),
        .pre_lim     (pre_lim),
        .run         (sh_run),
        .active      (sh_active),
        .pol         (sh_pol)
    );

    assign pwm_oe  = sh_run;
    assign pwm_out = sh_run & ~(sh_active ^ sh_pol);
endmodule

// File: rtl/pulse_chan_chk.sv
`timescale 1ns/1ps
// Temporal checks on the channel, attached by bind.
module pulse_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chan_en,
    input logic [1:0]       mode_sel,
    input logic             ext_trig_en,
    input logic             act_high,
    input logic [CNT_W-1:0] hi_val,
    input logic             trig_lvl,
    input logic             trig_rise,
    input logic             pre_tick,
    input logic             pwm_out,
    input logic             pwm_oe
);
    assert_disable_tristate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !pwm_oe);

    assert_enable_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && !ext_trig_en && !pwm_oe |=> pwm_oe && (pwm_out == act_high || hi_val == '0));

    assert_oneshot_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && ext_trig_en && mode_sel == 2'd1 && !pwm_oe && !trig_rise |=> !pwm_oe);

    assert_retrigger_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && pwm_oe && ext_trig_en && mode_sel == 2'd1 && trig_rise && hi_val != '0
        |=> pwm_out == act_high);

    assert_wrap_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && pwm_oe && !ext_trig_en && mode_sel == 2'd1 && pre_tick && hi_val != '0
        |=> pwm_out == act_high);

    assert_gate_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && ext_trig_en && mode_sel != 2'd1 && !pwm_oe && !trig_lvl |=> !pwm_oe);

    assert_gate_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && pwm_oe && ext_trig_en && mode_sel != 2'd1 && !trig_lvl
        |=> $stable(pwm_out) && pwm_oe);
endmodule

bind pulse_chan pulse_chan_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_pulse_chan.sv
`timescale 1ns/1ps
module tb_pulse_chan;
    localparam int WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        chan_en;
    logic [1:0]  mode_sel;
    logic        wide_res;
    logic        ext_trig_en;
    logic        act_high;
    logic [15:0] div_val;
    logic [15:0] hi_val;
    logic [15:0] lo_val;
    logic        trig_in;
    logic        pwm_out;
    logic        pwm_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pulse_chan dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .mode_sel(mode_sel),
        .wide_res(wide_res), .ext_trig_en(ext_trig_en), .act_high(act_high),
        .div_val(div_val), .hi_val(hi_val), .lo_val(lo_val), .trig_in(trig_in),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
        end
    endtask

    function automatic logic exp_active(input int md, input bit wd, input int L, input int M,
                                        input int N, input int k);
        int per;
        int m_eff;
        if (md == 0) begin
            per   = wd ? 65535 : 255;
            m_eff = wd ? M : (M % 256);
            return ((k / (L + 1)) % per) < m_eff;
        end else if (md == 2) begin
            per = M + N;
            if (per == 0) return 1'b0;
            return ((k / (L + 1)) % per) < M;
        end
        return (k % (L + 1)) < M;
    endfunction

    task automatic set_cfg(input int md, input bit wd, input bit ext, input bit pol,
                           input int L, input int M, input int N);
        mode_sel    = md[1:0];
        wide_res    = wd;
        ext_trig_en = ext;
        act_high    = pol;
        div_val     = L[15:0];
        hi_val      = M[15:0];
        lo_val      = N[15:0];
    endtask

    task automatic stop_chan();
        chan_en = 1'b0;
        step();
        check("R9", pwm_oe, 1'b0);
        step();
    endtask

    task automatic run_wave(input string req, input int md, input bit wd, input bit pol,
                            input int L, input int M, input int N, input int len);
        logic ea;
        set_cfg(md, wd, 1'b0, pol, L, M, N);
        chan_en = 1'b1;
        for (int k = 0; k < len; k++) begin
            step();
            ea = exp_active(md, wd, L, M, N, k);
            check((k == 0) ? "R12" : req, pwm_oe, 1'b1);
            check(req, pwm_out, ~(ea ^ pol));
        end
        stop_chan();
    endtask

    // External one-shot: wait, trigger, pulse of (L+1)*M cycles.
    task automatic oneshot_ext(input int L, input int M);
        set_cfg(1, 1'b0, 1'b1, 1'b1, L, M, 0);
        chan_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R4", pwm_oe, 1'b0);
        end
        trig_in = 1'b1;
        step();
        step();
        check("R4", pwm_oe, 1'b0);
        trig_in = 1'b0;
        for (int k = 0; k < (L + 1) * M + 6; k++) begin
            step();
            check("R4", pwm_oe, 1'b1);
            check("R4", pwm_out, k < (L + 1) * M);
        end
        stop_chan();
    endtask

    // Retrigger during a pulse: second trigger set after sample j restarts at j+3.
    task automatic retrig(input int L, input int M, input int j);
        int w;
        int k2;
        logic ea;
        w  = (L + 1) * M;
        k2 = j + 3;
        set_cfg(1, 1'b0, 1'b1, 1'b1, L, M, 0);
        chan_en = 1'b1;
        trig_in = 1'b1;
        step();
        step();
        trig_in = 1'b0;
        for (int k = 0; k < k2 + w + 6; k++) begin
            step();
            ea = (k < w) || (k >= k2 && (k - k2) < w);
            check("R5", pwm_out, ea);
            if (k == j) trig_in = 1'b1;
            if (k == j + 2) trig_in = 1'b0;
        end
        stop_chan();
    endtask

    // Level gating in dual-width mode: low after sample j for h samples.
    task automatic gate_freeze(input int L, input int M, input int N, input int j, input int h);
        int v;
        logic ea;
        set_cfg(2, 1'b0, 1'b1, 1'b1, L, M, N);
        chan_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R11", pwm_oe, 1'b0);
        end
        trig_in = 1'b1;
        step();
        step();
        check("R11", pwm_oe, 1'b0);
        v = 0;
        for (int k = 0; k < 60; k++) begin
            step();
            if (k > 0 && !(k >= j + 3 && k <= j + h + 2)) v++;
            ea = exp_active(2, 1'b0, L, M, N, v);
            check("R11", pwm_oe, 1'b1);
            check("R11", pwm_out, ea);
            if (k == j) trig_in = 1'b0;
            if (k == j + h) trig_in = 1'b1;
        end
        trig_in = 1'b0;
        stop_chan();
    endtask

    initial begin
        #(WD_CYCLES * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ms8 [7] = '{0, 1, 7, 128, 254, 255, 300};
        int ms1 [5] = '{0, 1, 3, 6, 9};
        int ms16 [3] = '{0, 300, 65535};
        logic ea;
        rst_n   = 1'b0;
        chan_en = 1'b0;
        trig_in = 1'b0;
        set_cfg(0, 1'b0, 1'b0, 1'b1, 0, 0, 0);
        step();
        step();
        check("R1", pwm_oe, 1'b0);
        check("R1", pwm_out, 1'b0);
        rst_n = 1'b1;
        step();
        step();
        check("R1", pwm_oe, 1'b0);
        check("R1", pwm_out, 1'b0);

        // R2: fixed period, narrow resolution
        for (int l = 0; l < 3; l++)
            foreach (ms8[i]) run_wave("R2", 0, 1'b0, 1'b1, l, ms8[i], 0, 2 * 255 * (l + 1) + 3);

        // R3: fixed period, wide resolution
        foreach (ms16[i]) run_wave("R3", 0, 1'b1, 1'b1, 0, ms16[i], 0, 700);
        run_wave("R3", 0, 1'b1, 1'b1, 1, 200, 0, 700);

        // R7: dual width sweep
        for (int l = 0; l < 4; l++)
            for (int m = 0; m < 4; m++)
                for (int n = 0; n < 4; n++)
                    if (m + n > 0 && l != 2)
                        run_wave("R7", 2, 1'b0, 1'b1, l, m, n, 2 * (m + n) * (l + 1) + 2);
        run_wave("R7", 2, 1'b0, 1'b1, 0, 0, 0, 10);

        // R6: internal one-shot
        for (int l = 0; l < 6; l += 2)
            foreach (ms1[i]) run_wave("R6", 1, 1'b0, 1'b1, l, ms1[i], 0, 3 * (l + 1) + 2);
        run_wave("R6", 1, 1'b0, 1'b1, 5, 4, 0, 20);

        // R8: inverted polarity
        run_wave("R8", 2, 1'b0, 1'b0, 1, 2, 3, 24);
        run_wave("R8", 0, 1'b0, 1'b0, 0, 5, 0, 300);
        run_wave("R8", 1, 1'b0, 1'b0, 3, 2, 0, 16);

        // R4, R5: external one-shot and retrigger
        for (int l = 0; l < 4; l++) begin
            oneshot_ext(l, 1);
            oneshot_ext(l, 2);
            oneshot_ext(l, 5);
        end
        retrig(0, 10, 4);
        retrig(1, 4, 5);

        // R11: level gating
        gate_freeze(0, 4, 4, 5, 6);
        gate_freeze(1, 3, 2, 7, 4);

        // R10: dual-width change mid-cycle
        set_cfg(2, 1'b0, 1'b0, 1'b1, 0, 3, 3);
        chan_en = 1'b1;
        for (int k = 0; k < 30; k++) begin
            step();
            ea = (k < 6) ? (k < 3) : (((k - 6) % 6) < 5);
            check("R10", pwm_out, ea);
            if (k == 1) begin
                hi_val = 16'd5;
                lo_val = 16'd1;
            end
        end
        stop_chan();

        // R10: fixed-period change mid-cycle
        set_cfg(0, 1'b0, 1'b0, 1'b1, 0, 10, 0);
        chan_en = 1'b1;
        for (int k = 0; k < 400; k++) begin
            step();
            ea = (k < 255) ? (k < 10) : ((k - 255) < 100);
            check("R10", pwm_out, ea);
            if (k == 2) hi_val = 16'd100;
        end
        stop_chan();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule